// File: doc/BRIEF.md
# Ethernet Transmit Framer

This block turns a payload byte stream into a complete frame for the wire. It adds everything around the payload itself. A frame begins with a fixed preamble and start delimiter. A destination address field and the station's own source address follow. The block can insert a two-byte length field, then passes the payload through, and ends with a 16-bit or 32-bit frame check sequence computed as the bytes go by. Once a frame ends, the block keeps a fixed interframe gap before it accepts the next start.

A frame begins with `start_i`. The destination address, address length, CRC options, length option and declared payload length are captured on that cycle. Payload bytes arrive on a valid/ready handshake, and the last byte carries an end mark. Each output byte is marked by `tx_valid_o`. `tx_active_o` is high from the first preamble byte through the last byte of the frame. The output is combinational, so a payload byte leaves in the same cycle it is accepted, and the CRC register updates at the end of that cycle.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `tx_active_o`, `tx_valid_o` and `pl_ready_o` are all 0.
- R2: A start accepted in idle makes the next cycle the first frame cycle. Each frame opens with seven bytes of 0x55, then one byte of 0xD5.
- R3: After the delimiter, the destination field is sent, then the source field (`station_addr_i`). Each field is `addr_len_i` bytes long and is sent low byte first (byte k is bits 8k+7:8k). A length of 0 removes both fields, and values above 6 are treated as 6.
- R4: When `len_auto_i` is 1, the two bytes after the source field carry `len_i`, high byte first. When it is 0, no length bytes are inserted.
- R5: Payload bytes leave in the order they are accepted. `pl_ready_o` is high only during the payload phase. A cycle in that phase without `pl_valid_i` emits no byte.
- R6: With `crc32_sel_i`=1, the frame check uses the reflected polynomial 0x04C11DB7 with an all-ones start value, inverted at the end. It covers the address, length and payload bytes and is appended lowest byte first, four bytes.
- R7: With `crc32_sel_i`=0, the frame check uses the non-reflected polynomial 0x1021 with start value 0xFFFF and no final inversion. It is appended high byte first, two bytes.
- R8: With `crc_en_i`=0, the frame ends right after the last payload byte.
- R9: After the last byte of a frame, a start is ignored for the next 11 cycles. If start is held high, exactly 12 idle cycles separate frames.
- R10: A start during a frame is ignored, and input changes after the start cycle do not alter the frame being sent.
- R11: `tx_valid_o` is never high while `tx_active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a frame |
| dst_addr_i | input | 48 | Destination address, byte k at bits 8k+7:8k |
| station_addr_i | input | 48 | Station source address, same byte layout |
| addr_len_i | input | 3 | Address field length in bytes (0 to 6) |
| crc32_sel_i | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check |
| crc_en_i | input | 1 | Append the frame check sequence |
| len_auto_i | input | 1 | Insert the length field |
| len_i | input | 16 | Declared payload byte count for the length field |
| pl_data_i | input | 8 | Payload byte |
| pl_valid_i | input | 1 | Payload byte present |
| pl_last_i | input | 1 | Marks the final payload byte |
| pl_ready_o | output | 1 | Block accepts a payload byte this cycle |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | `tx_data_o` carries a frame byte |
| tx_active_o | output | 1 | Frame in progress |

## Verification
The bench uses the default parameters: a six-byte address limit, a seven-byte preamble and a twelve-cycle gap. With these defaults, every address length from 0 to 6 can be reached, plus the clamped value 7 on the three-bit length input. The gap is short enough to measure to the exact cycle when start is held through it, and to probe with a pulse in the middle of it. Random frames mix both CRC widths, CRC on and off, length insertion on and off, and payload stalls, with payloads up to 24 bytes. Directed frames cover the one-byte payload with no address, a start raised during a frame, and the back-to-back gap.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DST,
        ST_SRC,
        ST_LEN,
        ST_DATA,
        ST_FCS
    } tx_state_e;

    // Reflected 32-bit CRC step over one byte
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

    // Non-reflected 16-bit CRC step over one byte
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_crc_gen.sv
module tx_crc_gen
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        upd_i,
    input  logic        sel32_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr_i) begin
            crc_d = 32'hFFFF_FFFF;
        end else if (upd_i) begin
            crc_d = sel32_i ? crc32_step(crc_q, data_i)
                            : {16'h0000, crc16_step(crc_q[15:0], data_i)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 32'hFFFF_FFFF;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    // R6
    clr_upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !upd_i);
endmodule

// File: rtl/tx_ifg_timer.sv
module tx_ifg_timer #(
    parameter int IFG_BYTES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int W = $clog2(IFG_BYTES + 1);

    logic [W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (load_i)                gap_d = W'(IFG_BYTES - 1);
        else if (gap_q != '0)      gap_d = gap_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign busy_o = (gap_q != '0);

    // R9
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int MAX_ADDR  = 6,
    parameter int PRE_BYTES = 7,
    parameter int IFG_BYTES = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [8*MAX_ADDR-1:0]      dst_addr_i,
    input  logic [8*MAX_ADDR-1:0]      station_addr_i,
    input  logic [$clog2(MAX_ADDR+1)-1:0] addr_len_i,
    input  logic                       crc32_sel_i,
    input  logic                       crc_en_i,
    input  logic                       len_auto_i,
    input  logic [15:0]                len_i,
    input  logic [7:0]                 pl_data_i,
    input  logic                       pl_valid_i,
    input  logic                       pl_last_i,
    output logic                       pl_ready_o,
    output logic [7:0]                 tx_data_o,
    output logic                       tx_valid_o,
    output logic                       tx_active_o
);
    localparam int AW      = 8 * MAX_ADDR;
    localparam int ALW     = $clog2(MAX_ADDR + 1);
    localparam int CNT_MAX = (PRE_BYTES > MAX_ADDR) ? ((PRE_BYTES > 4) ? PRE_BYTES : 4)
                                                    : ((MAX_ADDR > 4) ? MAX_ADDR : 4);
    localparam int CW      = $clog2(CNT_MAX);

    typedef struct packed {
        tx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [ALW-1:0] alen;
        logic           c32;
        logic           cen;
        logic           lauto;
        logic [15:0]    len;
        logic [AW-1:0]  dst;
        logic [AW-1:0]  src;
    } fr_t;

    fr_t         r_d, r_q;
    logic        crc_clr, crc_upd, gap_load, gap_busy;
    logic [31:0] crc_w;
    logic [7:0]  out_byte;
    logic        out_vld, rdy;
    tx_state_e   after_src;
    logic        fcs_last;

    tx_crc_gen u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (crc_clr),
        .upd_i   (crc_upd),
        .sel32_i (r_q.c32),
        .data_i  (out_byte),
        .crc_o   (crc_w)
    );

    tx_ifg_timer #(.IFG_BYTES(IFG_BYTES)) u_ifg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap_load),
        .busy_o (gap_busy)
    );

    always_comb begin
        r_d       = r_q;
        out_byte  = 8'h00;
        out_vld   = 1'b0;
        rdy       = 1'b0;
        crc_clr   = 1'b0;
        crc_upd   = 1'b0;
        gap_load  = 1'b0;
        after_src = r_q.lauto ? ST_LEN : ST_DATA;
        fcs_last  = r_q.c32 ? (r_q.cnt == CW'(3)) : (r_q.cnt == CW'(1));

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i && !gap_busy) begin
                    r_d.st    = ST_PRE;
                    r_d.cnt   = '0;
                    r_d.alen  = (addr_len_i > ALW'(MAX_ADDR)) ? ALW'(MAX_ADDR) : addr_len_i;
                    r_d.c32   = crc32_sel_i;
                    r_d.cen   = crc_en_i;
                    r_d.lauto = len_auto_i;
                    r_d.len   = len_i;
                    r_d.dst   = dst_addr_i;
                    r_d.src   = station_addr_i;
                    crc_clr   = 1'b1;
                end
            end
            ST_PRE: begin
                out_byte = 8'h55;
                out_vld  = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(PRE_BYTES - 1)) begin
                    r_d.st  = ST_SFD;
                    r_d.cnt = '0;
                end
            end
            ST_SFD: begin
                out_byte = 8'hD5;
                out_vld  = 1'b1;
                r_d.cnt  = '0;
                r_d.st   = (r_q.alen != '0) ? ST_DST : after_src;
            end
            ST_DST: begin
                out_byte = r_q.dst[8*r_q.cnt +: 8];
                out_vld  = 1'b1;
                crc_upd  = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(r_q.alen - 1'b1)) begin
                    r_d.st  = ST_SRC;
                    r_d.cnt = '0;
                end
            end
            ST_SRC: begin
                out_byte = r_q.src[8*r_q.cnt +: 8];
                out_vld  = 1'b1;
                crc_upd  = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(r_q.alen - 1'b1)) begin
                    r_d.st  = after_src;
                    r_d.cnt = '0;
                end
            end
            ST_LEN: begin
                out_byte = (r_q.cnt == '0) ? r_q.len[15:8] : r_q.len[7:0];
                out_vld  = 1'b1;
                crc_upd  = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(1)) begin
                    r_d.st  = ST_DATA;
                    r_d.cnt = '0;
                end
            end
            ST_DATA: begin
                rdy = 1'b1;
                if (pl_valid_i) begin
                    out_byte = pl_data_i;
                    out_vld  = 1'b1;
                    crc_upd  = 1'b1;
                    if (pl_last_i) begin
                        r_d.cnt = '0;
                        if (r_q.cen) begin
                            r_d.st = ST_FCS;
                        end else begin
                            r_d.st   = ST_IDLE;
                            gap_load = 1'b1;
                        end
                    end
                end
            end
            ST_FCS: begin
                out_byte = r_q.c32 ? ~crc_w[8*r_q.cnt +: 8]
                                   : ((r_q.cnt == '0) ? crc_w[15:8] : crc_w[7:0]);
                out_vld  = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (fcs_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.cnt  = '0;
                    gap_load = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_data_o   = out_byte;
    assign tx_valid_o  = out_vld;
    assign pl_ready_o  = rdy;
    assign tx_active_o = (r_q.st != ST_IDLE);

    // R11
    valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> tx_active_o);

    // R2
    pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active_o) |-> (tx_valid_o && tx_data_o == 8'h55));

    // R9
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active_o && gap_busy) |=> !tx_active_o);

    // R5
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready_o |-> tx_active_o);

    // R6
    fcs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid_i && pl_ready_o && pl_last_i && r_q.cen) |=> (tx_valid_o && tx_active_o));
endmodule

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;
    import eth_tx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [47:0] dst_addr_i;
    logic [47:0] station_addr_i;
    logic [2:0]  addr_len_i;
    logic        crc32_sel_i, crc_en_i, len_auto_i;
    logic [15:0] len_i;
    logic [7:0]  pl_data_i;
    logic        pl_valid_i, pl_last_i;
    logic        pl_ready_o;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o, tx_active_o;

    int nvec  = 0;
    int nfail = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];
    logic [7:0] pay[$];
    logic       cur_cen;
    logic [31:0] c32v;
    logic [15:0] c16v;

    always #4 clk = ~clk;

    eth_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dst_addr_i(dst_addr_i), .station_addr_i(station_addr_i),
        .addr_len_i(addr_len_i), .crc32_sel_i(crc32_sel_i), .crc_en_i(crc_en_i),
        .len_auto_i(len_auto_i), .len_i(len_i),
        .pl_data_i(pl_data_i), .pl_valid_i(pl_valid_i), .pl_last_i(pl_last_i),
        .pl_ready_o(pl_ready_o), .tx_data_o(tx_data_o),
        .tx_valid_o(tx_valid_o), .tx_active_o(tx_active_o)
    );

    function automatic logic [31:0] ref_c32(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb = r[0] ^ d[b];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_c16(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb = r[15] ^ d[b];
            r = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic add_hdr(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic add_body(input logic [7:0] b, input string t);
        add_hdr(b, t);
        c32v = ref_c32(c32v, b);
        c16v = ref_c16(c16v, b);
    endtask

    task automatic prep_frame(input int alen, input bit c32, input bit cen,
                              input bit la, input int plen);
        int leff;
        logic [31:0] fin;
        dst_addr_i     = {$urandom, $urandom};
        station_addr_i = {$urandom, $urandom};
        addr_len_i     = 3'(alen);
        crc32_sel_i    = c32;
        crc_en_i       = cen;
        len_auto_i     = la;
        len_i          = 16'(plen);
        pl_valid_i     = 1'b0;
        pl_last_i      = 1'b0;
        cur_cen        = cen;
        leff = (alen > 6) ? 6 : alen;
        exp_q.delete(); tag_q.delete(); pay.delete();
        c32v = 32'hFFFF_FFFF;
        c16v = 16'hFFFF;
        for (int k = 0; k < 7; k++) add_hdr(8'h55, "R2 preamble");
        add_hdr(8'hD5, "R2 delimiter");
        for (int k = 0; k < leff; k++) add_body(dst_addr_i[8*k +: 8], "R3 destination");
        for (int k = 0; k < leff; k++) add_body(station_addr_i[8*k +: 8], "R3 source");
        if (la) begin
            add_body(8'(plen >> 8), "R4 length hi");
            add_body(8'(plen), "R4 length lo");
        end
        for (int k = 0; k < plen; k++) begin
            pay.push_back(8'($urandom));
            add_body(pay[k], "R5 payload");
        end
        if (cen) begin
            if (c32) begin
                fin = ~c32v;
                for (int k = 0; k < 4; k++) add_hdr(fin[8*k +: 8], "R6 crc32");
            end else begin
                add_hdr(c16v[15:8], "R7 crc16 hi");
                add_hdr(c16v[7:0], "R7 crc16 lo");
            end
        end
    endtask

    // runs one frame; pre=1 means its first byte was already captured
    task automatic run_frame(input bit pre, input bit stall, input bit mid, output int bad);
        bit seen = pre;
        bit done = 0;
        int p = 0;
        int it = 0;
        int first = -1;
        int n;
        if (!pre) got_q.delete();
        while (!done) begin
            @(negedge clk);
            if (tx_active_o && !seen) begin
                seen = 1;
                first = it;
            end
            if (mid && seen && got_q.size() == 3) begin
                start_i    = 1'b1;
                dst_addr_i = ~dst_addr_i;
                addr_len_i = 3'd1;
            end else begin
                start_i = !seen;
            end
            pl_valid_i = (p < pay.size()) && (stall ? ($urandom % 4 != 0) : 1'b1);
            pl_data_i  = (p < pay.size()) ? pay[p] : 8'h00;
            pl_last_i  = (p == pay.size() - 1);
            #1;
            if (tx_valid_o) got_q.push_back(tx_data_o);
            if (tx_valid_o && !tx_active_o) chk(0, "R11 valid outside frame", 1, 0);
            if (pl_ready_o && !pl_valid_i && tx_valid_o) chk(0, "R5 byte during stall", 1, 0);
            if (pl_valid_i && pl_ready_o) p++;
            if (seen && !tx_active_o) done = 1;
            it++;
            if (it > 600) begin
                chk(0, "R5 frame did not end", it, 0);
                done = 1;
            end
        end
        pl_valid_i = 1'b0;
        pl_last_i  = 1'b0;
        start_i    = 1'b0;
        if (!pre) chk(first == 1, "R2 first byte latency", first, 1);
        chk(got_q.size() == exp_q.size(), cur_cen ? "R6/R7 frame length" : "R8 frame length",
            got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (got_q[i] !== exp_q[i]) bad++;
            chk(got_q[i] === exp_q[i], tag_q[i], got_q[i], exp_q[i]);
        end
        if (got_q.size() != exp_q.size()) bad++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int bad;
        int idle;
        bit act_seen;
        void'($urandom(32'd4711));
        rst_n = 1'b0; start_i = 1'b0;
        dst_addr_i = '0; station_addr_i = '0; addr_len_i = '0;
        crc32_sel_i = 1'b0; crc_en_i = 1'b0; len_auto_i = 1'b0; len_i = '0;
        pl_data_i = '0; pl_valid_i = 1'b0; pl_last_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_active_o, "R1 active in reset", tx_active_o, 0);
        chk(!tx_valid_o, "R1 valid in reset", tx_valid_o, 0);
        chk(!pl_ready_o, "R1 ready in reset", pl_ready_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_active_o && !tx_valid_o && !pl_ready_o, "R1 idle after reset",
            {tx_active_o, tx_valid_o, pl_ready_o}, 0);

        // minimal frame: no address, no length, no crc (R8, R3)
        prep_frame(0, 1, 0, 0, 1);
        run_frame(0, 0, 0, bad);
        repeat (14) @(negedge clk);

        // address length above limit is clamped (R3), crc32 (R6)
        prep_frame(7, 1, 1, 1, 5);
        run_frame(0, 0, 0, bad);
        repeat (14) @(negedge clk);

        // start and input changes during the frame have no effect (R10)
        prep_frame(4, 0, 1, 1, 10);
        run_frame(0, 1, 1, bad);
        chk(bad == 0, "R10 frame altered by mid-frame start", bad, 0);
        act_seen = 0;
        repeat (20) begin
            @(negedge clk); #1;
            if (tx_active_o) act_seen = 1;
        end
        chk(!act_seen, "R10 extra frame after mid-frame start", act_seen, 0);

        // pulse of start inside the gap is ignored (R9)
        prep_frame(2, 0, 1, 0, 3);
        run_frame(0, 0, 0, bad);
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        act_seen = 0;
        repeat (20) begin
            @(negedge clk); #1;
            if (tx_active_o) act_seen = 1;
        end
        chk(!act_seen, "R9 start inside gap accepted", act_seen, 0);

        // held start: exact gap between frames (R9)
        prep_frame(6, 1, 1, 0, 4);
        run_frame(0, 0, 0, bad);
        prep_frame(3, 0, 1, 1, 6);
        start_i = 1'b1;
        idle = 1;
        forever begin
            @(negedge clk); #1;
            if (tx_active_o) break;
            idle++;
            if (idle > 100) break;
        end
        chk(idle == 12, "R9 idle cycles between frames", idle, 12);
        got_q.delete();
        if (tx_valid_o) got_q.push_back(tx_data_o);
        run_frame(1, 0, 0, bad);
        repeat (14) @(negedge clk);

        // random frames
        for (int f = 0; f < 40; f++) begin
            prep_frame($urandom % 8, $urandom % 2, $urandom % 2, $urandom % 2,
                       1 + ($urandom % 24));
            run_frame(0, $urandom % 2, 0, bad);
            repeat (14) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule